// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This engine services a set of DMA channels that software programs through a small word-write port. Each channel holds five words: source address, destination address, next-descriptor pointer, control and configuration. While the global enable input is high, the engine looks for channels that are enabled and not halted. It checks each one's flow type against the peripheral request lines. The lowest-numbered ready channel gets one element moved: a read from the source address, then a write of the same data to the destination address. After the move the addresses advance as configured and the transfer count drops by one.

When a channel's count reaches zero, the engine does one of two things. If the next-descriptor pointer is nonzero, it fetches a four-word descriptor from memory, and the channel stays enabled and carries on. If the pointer is zero, it clears the channel's enable bit. In both cases a flag in the control word can raise a per-channel terminal-count flag, which drives a combined interrupt line. All memory traffic uses a single request/acknowledge master port.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset, all channel words read zero, `tc_o`, `irq_o` and `chan_en_o` are zero, and `mem_req_o` is low.
- R2: A channel moves data only while `glb_en_i` is high, its configuration bit 0 (enable) is set and its configuration bit 18 (halt) is clear.
- R3: The configuration word gives the source peripheral number in bits [5:1], the destination peripheral number in bits [10:6] and the flow type in bits [13:11]. The request vector is `req_single_i | req_burst_i`. The flow types gate transfers as follows:
  - type 0 needs no request;
  - type 1 needs the destination request;
  - type 2 needs the source request;
  - type 3 needs both requests;
  - types 4 to 7 never transfer.
- R4: Each grant reads one element at the source address and writes the same data to the destination address. It then decrements the control count field [11:0] by one and leaves control bits [31:12] unchanged.
- R5: After each element, control bit 26 adds 2^ctrl[20:18] to the source address and control bit 27 adds 2^ctrl[23:21] to the destination address. An address whose bit is clear stays put.
- R6: When the count reaches zero and the pointer is nonzero, four words are read from pointer+0, +4, +8 and +12. They load source, destination, pointer and control, in that order, and the channel stays enabled.
- R7: When the count reaches zero and the pointer is zero, configuration bit 0 is cleared and the other configuration bits are kept.
- R8: At completion with control bit 31 set, `tc_o[ch]` is set. If bit 31 is clear, `tc_o[ch]` is not set. A set flag holds until `tc_clr_i[ch]` is pulsed, and `irq_o` is high while any flag is set.
- R9: When several channels are ready, the lowest-numbered one is served first.
- R10: `mem_req_o` and its address, direction and size are held until `mem_ack_i`. `mem_size_o` carries the width code: ctrl[20:18] for element reads, ctrl[23:21] for element writes, and 2 for descriptor reads.
- R11: A channel selected with a count of zero completes at once, without any memory access.
- R12: A write on the configuration port with `cfg_sel_i` 0 to 4 (source, destination, pointer, control, configuration) is read back on `cfg_rdata_o` for the same channel and selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global engine enable |
| cfg_we_i | input | 1 | Channel word write strobe |
| cfg_ch_i | input | CH_W | Channel index for write and read |
| cfg_sel_i | input | 3 | Word selector (0 src, 1 dst, 2 pointer, 3 control, 4 configuration) |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Selected channel word |
| req_single_i | input | 32 | Single request lines per peripheral |
| req_burst_i | input | 32 | Burst request lines per peripheral |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_size_o | output | 3 | Access width code, 2^n bytes |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 32 | Read data |
| chan_en_o | output | NUM_CH | Channel enable bits |
| tc_o | output | NUM_CH | Raw terminal-count flags |
| tc_clr_i | input | NUM_CH | Terminal-count flag clear |
| irq_o | output | 1 | OR of all terminal-count flags |

## Verification
The bench builds the engine with `NUM_CH` set to 4. With four channels, a priority race can run between channel 1 and channel 3 with an idle channel between them. A descriptor chain can run on channel 0 while other channels hold leftover settings. The full 32-line request vector is kept, so source and destination peripheral numbers are picked far apart. This shows that each flow type looks at the right line, and at both the single and the burst input.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 12;
  localparam int PER_W   = 5;
  localparam int NUM_REQ = 1 << PER_W;

  localparam int CONF_EN   = 0;
  localparam int CONF_HALT = 18;
  localparam int CTRL_SI   = 26;
  localparam int CTRL_DI   = 27;
  localparam int CTRL_TC   = 31;

  typedef enum logic [2:0] {
    W_SRC  = 3'd0,
    W_DST  = 3'd1,
    W_LLI  = 3'd2,
    W_CTRL = 3'd3,
    W_CONF = 3'd4
  } word_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_WR, S_UPD, S_DONE, S_LL0, S_LL1, S_LL2, S_LL3
  } st_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] lli;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] conf;
  } chan_t;

  function automatic logic [CNT_W-1:0] f_cnt(logic [WORD_W-1:0] c);
    return c[CNT_W-1:0];
  endfunction
  function automatic logic [2:0] f_swc(logic [WORD_W-1:0] c);
    return c[20:18];
  endfunction
  function automatic logic [2:0] f_dwc(logic [WORD_W-1:0] c);
    return c[23:21];
  endfunction
  function automatic logic [2:0] f_flow(logic [WORD_W-1:0] c);
    return c[13:11];
  endfunction
  function automatic logic [PER_W-1:0] f_sper(logic [WORD_W-1:0] c);
    return c[1 +: PER_W];
  endfunction
  function automatic logic [PER_W-1:0] f_dper(logic [WORD_W-1:0] c);
    return c[6 +: PER_W];
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_ll_pkg::*; #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CH_W-1:0]          cfg_ch_i,
  input  logic [2:0]               cfg_sel_i,
  input  logic [WORD_W-1:0]        cfg_wdata_i,
  input  logic [4:0]               eng_we_i,
  input  logic [CH_W-1:0]          eng_ch_i,
  input  chan_t                    eng_val_i,
  output chan_t [NUM_CH-1:0]       regs_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_c, hit_e;
    assign hit_c = cfg_we_i && (cfg_ch_i == CH_W'(g));
    assign hit_e = (eng_ch_i == CH_W'(g));
    chan_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        // engine update wins over a same-cycle software write
        if (hit_e && eng_we_i[W_SRC])            q.src  <= eng_val_i.src;
        else if (hit_c && cfg_sel_i == W_SRC)    q.src  <= cfg_wdata_i;
        if (hit_e && eng_we_i[W_DST])            q.dst  <= eng_val_i.dst;
        else if (hit_c && cfg_sel_i == W_DST)    q.dst  <= cfg_wdata_i;
        if (hit_e && eng_we_i[W_LLI])            q.lli  <= eng_val_i.lli;
        else if (hit_c && cfg_sel_i == W_LLI)    q.lli  <= cfg_wdata_i;
        if (hit_e && eng_we_i[W_CTRL])           q.ctrl <= eng_val_i.ctrl;
        else if (hit_c && cfg_sel_i == W_CTRL)   q.ctrl <= cfg_wdata_i;
        if (hit_e && eng_we_i[W_CONF])           q.conf <= eng_val_i.conf;
        else if (hit_c && cfg_sel_i == W_CONF)   q.conf <= cfg_wdata_i;
      end
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter import dma_ll_pkg::*; #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  chan_t [NUM_CH-1:0]  regs_i,
  input  logic [NUM_REQ-1:0]  req_i,
  input  logic                glb_en_i,
  output logic                gnt_vld_o,
  output logic [CH_W-1:0]     gnt_ch_o
);
  logic [NUM_CH-1:0] rdy;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_rdy
    logic elig, sreq, dreq, flow_ok;
    assign elig = glb_en_i && regs_i[g].conf[CONF_EN] && !regs_i[g].conf[CONF_HALT];
    assign sreq = req_i[f_sper(regs_i[g].conf)];
    assign dreq = req_i[f_dper(regs_i[g].conf)];
    always_comb begin
      unique case (f_flow(regs_i[g].conf))
        3'd0:    flow_ok = 1'b1;
        3'd1:    flow_ok = dreq;
        3'd2:    flow_ok = sreq;
        3'd3:    flow_ok = sreq && dreq;
        default: flow_ok = 1'b0;
      endcase
    end
    assign rdy[g] = elig && flow_ok;
  end

  // lowest index wins
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_ch_o  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        gnt_vld_o = 1'b1;
        gnt_ch_o  = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm import dma_ll_pkg::*; #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gnt_vld_i,
  input  logic [CH_W-1:0]     gnt_ch_i,
  input  chan_t [NUM_CH-1:0]  regs_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [WORD_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic [2:0]          mem_size_o,
  input  logic                mem_ack_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic [4:0]          eng_we_o,
  output logic [CH_W-1:0]     eng_ch_o,
  output chan_t               eng_val_o,
  output logic [NUM_CH-1:0]   tc_set_o
);
  st_e                 st_q, st_d;
  chan_t               cur_q;
  logic [CH_W-1:0]     ch_q;
  logic [WORD_W-1:0]   data_q;
  logic [CNT_W-1:0]    cnt_dec;
  logic [WORD_W-1:0]   src_nxt, dst_nxt;

  assign cnt_dec = f_cnt(cur_q.ctrl) - CNT_W'(1);
  assign src_nxt = cur_q.ctrl[CTRL_SI] ? cur_q.src + (WORD_W'(1) << f_swc(cur_q.ctrl)) : cur_q.src;
  assign dst_nxt = cur_q.ctrl[CTRL_DI] ? cur_q.dst + (WORD_W'(1) << f_dwc(cur_q.ctrl)) : cur_q.dst;
  assign eng_ch_o = ch_q;

  always_comb begin
    st_d        = st_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = data_q;
    mem_size_o  = 3'd2;
    eng_we_o    = '0;
    eng_val_o   = '{src: mem_rdata_i, dst: mem_rdata_i, lli: mem_rdata_i,
                    ctrl: mem_rdata_i, conf: regs_i[ch_q].conf & ~(WORD_W'(1) << CONF_EN)};
    tc_set_o    = '0;
    unique case (st_q)
      S_IDLE: if (gnt_vld_i)
                st_d = (f_cnt(regs_i[gnt_ch_i].ctrl) == '0) ? S_DONE : S_RD;
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q.src;
        mem_size_o = f_swc(cur_q.ctrl);
        if (mem_ack_i) st_d = S_WR;
      end
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = cur_q.dst;
        mem_size_o = f_dwc(cur_q.ctrl);
        if (mem_ack_i) st_d = S_UPD;
      end
      S_UPD: begin
        eng_we_o[W_SRC]  = cur_q.ctrl[CTRL_SI];
        eng_we_o[W_DST]  = cur_q.ctrl[CTRL_DI];
        eng_we_o[W_CTRL] = 1'b1;
        eng_val_o.src    = src_nxt;
        eng_val_o.dst    = dst_nxt;
        eng_val_o.ctrl   = {cur_q.ctrl[WORD_W-1:CNT_W], cnt_dec};
        st_d = (cnt_dec == '0) ? S_DONE : S_IDLE;
      end
      S_DONE: begin
        if (cur_q.ctrl[CTRL_TC]) tc_set_o[ch_q] = 1'b1;
        if (cur_q.lli != '0) begin
          st_d = S_LL0;
        end else begin
          eng_we_o[W_CONF] = 1'b1;
          st_d = S_IDLE;
        end
      end
      S_LL0, S_LL1, S_LL2, S_LL3: begin
        mem_req_o = 1'b1;
        unique case (st_q)
          S_LL0:   mem_addr_o = cur_q.lli;
          S_LL1:   mem_addr_o = cur_q.lli + WORD_W'(4);
          S_LL2:   mem_addr_o = cur_q.lli + WORD_W'(8);
          default: mem_addr_o = cur_q.lli + WORD_W'(12);
        endcase
        if (mem_ack_i) begin
          unique case (st_q)
            S_LL0:   begin eng_we_o[W_SRC]  = 1'b1; st_d = S_LL1;  end
            S_LL1:   begin eng_we_o[W_DST]  = 1'b1; st_d = S_LL2;  end
            S_LL2:   begin eng_we_o[W_LLI]  = 1'b1; st_d = S_LL3;  end
            default: begin eng_we_o[W_CTRL] = 1'b1; st_d = S_IDLE; end
          endcase
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      ch_q   <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && gnt_vld_i) begin
        cur_q <= regs_i[gnt_ch_i];
        ch_q  <= gnt_ch_i;
      end
      if (st_q == S_RD && mem_ack_i) data_q <= mem_rdata_i;
      if (st_q == S_UPD) begin
        cur_q.src  <= src_nxt;
        cur_q.dst  <= dst_nxt;
        cur_q.ctrl <= {cur_q.ctrl[WORD_W-1:CNT_W], cnt_dec};
      end
    end
  end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine import dma_ll_pkg::*; #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 glb_en_i,
  input  logic                 cfg_we_i,
  input  logic [CH_W-1:0]      cfg_ch_i,
  input  logic [2:0]           cfg_sel_i,
  input  logic [31:0]          cfg_wdata_i,
  output logic [31:0]          cfg_rdata_o,
  input  logic [31:0]          req_single_i,
  input  logic [31:0]          req_burst_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [31:0]          mem_addr_o,
  output logic [31:0]          mem_wdata_o,
  output logic [2:0]           mem_size_o,
  input  logic                 mem_ack_i,
  input  logic [31:0]          mem_rdata_i,
  output logic [NUM_CH-1:0]    chan_en_o,
  output logic [NUM_CH-1:0]    tc_o,
  input  logic [NUM_CH-1:0]    tc_clr_i,
  output logic                 irq_o
);
  chan_t [NUM_CH-1:0] regs;
  logic [4:0]         eng_we;
  logic [CH_W-1:0]    eng_ch;
  chan_t              eng_val;
  logic               gnt_vld;
  logic [CH_W-1:0]    gnt_ch;
  logic [NUM_CH-1:0]  tc_set, tc_q;

  dma_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_ch_i, .cfg_sel_i, .cfg_wdata_i,
    .eng_we_i(eng_we), .eng_ch_i(eng_ch), .eng_val_i(eng_val),
    .regs_o(regs)
  );

  dma_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .regs_i(regs), .req_i(req_single_i | req_burst_i), .glb_en_i,
    .gnt_vld_o(gnt_vld), .gnt_ch_o(gnt_ch)
  );

  dma_xfer_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk_i, .rst_ni,
    .gnt_vld_i(gnt_vld), .gnt_ch_i(gnt_ch), .regs_i(regs),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_size_o,
    .mem_ack_i, .mem_rdata_i,
    .eng_we_o(eng_we), .eng_ch_o(eng_ch), .eng_val_o(eng_val),
    .tc_set_o(tc_set)
  );

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= '0;
    else         tc_q <= (tc_q & ~tc_clr_i) | tc_set;
  end

  assign tc_o  = tc_q;
  assign irq_o = |tc_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    assign chan_en_o[g] = regs[g].conf[CONF_EN];
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (int'(cfg_ch_i) < NUM_CH) begin
      unique case (cfg_sel_i)
        W_SRC:   cfg_rdata_o = regs[cfg_ch_i].src;
        W_DST:   cfg_rdata_o = regs[cfg_ch_i].dst;
        W_LLI:   cfg_rdata_o = regs[cfg_ch_i].lli;
        W_CTRL:  cfg_rdata_o = regs[cfg_ch_i].ctrl;
        W_CONF:  cfg_rdata_o = regs[cfg_ch_i].conf;
        default: cfg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_ll_checker.sv
module dma_ll_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [31:0]       mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic [2:0]        mem_size_o,
  input logic              mem_ack_i,
  input logic [31:0]       mem_rdata_i,
  input logic [NUM_CH-1:0] tc_o,
  input logic [NUM_CH-1:0] tc_clr_i
);
  logic [31:0] last_rd;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_rd <= '0;
    else if (mem_req_o && mem_ack_i && !mem_we_o) last_rd <= mem_rdata_i;
  end

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_size_o));

  a_r4_wdata_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o == last_rd);

  a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !$past(mem_req_o && mem_we_o) |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

  a_r8_single_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_o & ~$past(tc_o)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tc
    a_r8_tc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(tc_o[g]) && !$past(tc_clr_i[g]) |-> tc_o[g]);
  end
endmodule

bind dma_ll_engine dma_ll_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_size_o(mem_size_o),
  .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
  .tc_o(tc_o), .tc_clr_i(tc_clr_i)
);

// File: tb/tb_dma_ll_engine.sv
module tb_dma_ll_engine;
  localparam int CLK_P  = 10;
  localparam int NCH    = 4;
  localparam int WD_MAX = 100000;

  logic        clk = 0, rst_n = 0, glb_en = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_ch = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [31:0] req_s = 0, req_b = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [2:0]  mem_size;
  logic [NCH-1:0] chan_en, tc, tc_clr = 0;
  logic        irq;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] mem [0:255];
  logic [31:0] wlog [0:63];
  logic [2:0]  slog;

  always #(CLK_P/2) clk = ~clk;

  dma_ll_engine #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_single_i(req_s), .req_burst_i(req_b),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_size_o(mem_size),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .chan_en_o(chan_en), .tc_o(tc), .tc_clr_i(tc_clr), .irq_o(irq)
  );

  // behavioural memory: one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wlog[wr_cnt[5:0]]  <= mem_addr;
        slog               <= mem_size;
        wr_cnt             <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] mk_ctrl(int cnt, int sw, int dw, bit si, bit di, bit t);
    return {t, 3'b0, di, si, 2'b0, 3'(dw), 3'(sw), 6'b0, 12'(cnt)};
  endfunction
  function automatic logic [31:0] mk_conf(bit en, int sp, int dp, int flow, bit halt);
    return {13'b0, halt, 4'b0, 3'(flow), 5'(dp), 5'(sp), en};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(int ch, int sel, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(int ch, int sel, output logic [31:0] v);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_sel = 3'(sel);
    #1 v = cfg_rdata;
  endtask

  task automatic setup(int ch, logic [31:0] s, logic [31:0] d, logic [31:0] l, logic [31:0] c, logic [31:0] f);
    cfg_wr(ch, 0, s); cfg_wr(ch, 1, d); cfg_wr(ch, 2, l); cfg_wr(ch, 3, c); cfg_wr(ch, 4, f);
  endtask

  task automatic wait_off(int ch);
    for (int i = 0; i < 400 && chan_en[ch]; i++) @(negedge clk);
  endtask

  task automatic pulse_clr(int ch);
    @(negedge clk); tc_clr[ch] = 1;
    @(negedge clk); tc_clr = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 chan_en", 32'(chan_en), 0);
    cfg_rd(2, 3, v); chk("R1 ctrl word", v, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    cfg_wr(3, 2, 32'hA5A5_0040);
    cfg_rd(3, 2, v); chk("R12 readback", v, 32'hA5A5_0040);
    cfg_rd(2, 2, v); chk("R12 other channel", v, 0);
    cfg_wr(3, 2, 0);
  endtask

  task automatic t_mem2mem;
    logic [31:0] v; int w0;
    glb_en = 0;
    setup(0, 32'h100, 32'h200, 0, mk_ctrl(3, 2, 2, 1, 1, 1), mk_conf(1, 0, 0, 0, 0));
    w0 = wr_cnt;
    repeat (30) @(negedge clk);
    chk("R2 global off", 32'(wr_cnt - w0), 0);
    glb_en = 1;
    wait_off(0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) chk("R4 data copy", mem[8'h80 + i], mem[8'h40 + i]);
    cfg_rd(0, 0, v); chk("R5 src inc", v, 32'h10C);
    cfg_rd(0, 1, v); chk("R5 dst inc", v, 32'h20C);
    cfg_rd(0, 3, v); chk("R4 ctrl upper kept", v, mk_ctrl(0, 2, 2, 1, 1, 1));
    cfg_rd(0, 4, v); chk("R7 enable cleared", v, mk_conf(0, 0, 0, 0, 0));
    chk("R10 write size", 32'(slog), 2);
    chk("R8 tc set", 32'(tc), 1);
    chk("R8 irq", 32'(irq), 1);
    pulse_clr(0);
    chk("R8 tc cleared", 32'(tc), 0);
  endtask

  task automatic t_halt;
    int w0;
    setup(1, 32'h100, 32'h300, 0, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 1));
    w0 = wr_cnt;
    repeat (40) @(negedge clk);
    chk("R2 halted no write", 32'(wr_cnt - w0), 0);
    chk("R2 halted still enabled", 32'(chan_en[1]), 1);
    cfg_wr(1, 4, 0);
  endtask

  task automatic run_flow(int flow, logic [31:0] s1, logic [31:0] b1, logic [31:0] s2, logic [31:0] b2, bit go);
    int w0;
    mem[8'hD0] = 32'h0;
    setup(1, 32'h300, 32'h340, 0, mk_ctrl(1, 2, 2, 0, 0, 0), mk_conf(1, 5, 3, flow, 0));
    w0 = wr_cnt;
    req_s = s1; req_b = b1;
    repeat (40) @(negedge clk);
    chk($sformatf("R3 flow%0d not ready", flow), 32'(wr_cnt - w0), 0);
    req_s = s2; req_b = b2;
    if (go) begin
      wait_off(1);
      repeat (2) @(negedge clk);
      chk($sformatf("R3 flow%0d moved", flow), mem[8'hD0], mem[8'hC0]);
      chk("R8 no tc without bit31", 32'(tc), 0);
    end else begin
      repeat (40) @(negedge clk);
      chk($sformatf("R3 flow%0d never", flow), 32'(wr_cnt - w0), 0);
      chk("R3 still enabled", 32'(chan_en[1]), 1);
    end
    req_s = 0; req_b = 0;
    cfg_wr(1, 4, 0);
  endtask

  task automatic t_byte;
    logic [31:0] v;
    setup(2, 32'h180, 32'h1C0, 0, mk_ctrl(2, 0, 0, 1, 0, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(2);
    cfg_rd(2, 0, v); chk("R5 byte src inc", v, 32'h182);
    cfg_rd(2, 1, v); chk("R5 dst fixed", v, 32'h1C0);
    chk("R10 byte size", 32'(slog), 0);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    mem[8'hE0] = 32'h240; mem[8'hE1] = 32'h280; mem[8'hE2] = 0;
    mem[8'hE3] = mk_ctrl(2, 2, 2, 1, 1, 1);
    setup(0, 32'h100, 32'h2C0, 32'h380, mk_ctrl(1, 2, 2, 1, 1, 0), mk_conf(1, 0, 0, 0, 0));
    wait_off(0);
    repeat (2) @(negedge clk);
    chk("R6 first descriptor", mem[8'hB0], mem[8'h40]);
    chk("R6 second desc word0", mem[8'hA0], mem[8'h90]);
    chk("R6 second desc word1", mem[8'hA1], mem[8'h91]);
    cfg_rd(0, 0, v); chk("R6 src loaded", v, 32'h248);
    cfg_rd(0, 2, v); chk("R6 pointer loaded", v, 0);
    chk("R8 tc on chain end", 32'(tc), 1);
    pulse_clr(0);
  endtask

  task automatic t_prio;
    int w0;
    glb_en = 0;
    setup(3, 32'h100, 32'h308, 0, mk_ctrl(1, 2, 2, 0, 0, 0), mk_conf(1, 0, 0, 0, 0));
    setup(1, 32'h104, 32'h304, 0, mk_ctrl(1, 2, 2, 0, 0, 0), mk_conf(1, 0, 0, 0, 0));
    w0 = wr_cnt;
    glb_en = 1;
    wait_off(1); wait_off(3);
    repeat (2) @(negedge clk);
    chk("R9 first served", wlog[w0[5:0]], 32'h304);
    chk("R9 second served", wlog[6'(w0 + 1)], 32'h308);
  endtask

  task automatic t_zero;
    int r0;
    r0 = rd_cnt;
    setup(0, 32'h100, 32'h200, 0, mk_ctrl(0, 2, 2, 1, 1, 1), mk_conf(1, 0, 0, 0, 0));
    wait_off(0);
    repeat (2) @(negedge clk);
    chk("R11 no access", 32'(rd_cnt - r0), 0);
    chk("R11 completion flag", 32'(tc), 1);
    pulse_clr(0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_cfg;
    t_mem2mem;
    t_halt;
    run_flow(1, 0, 0, 0, 32'h8, 1);
    run_flow(2, 32'h8, 0, 32'h28, 0, 1);
    run_flow(3, 32'h20, 0, 32'h20, 32'h8, 1);
    run_flow(6, 0, 0, '1, '1, 0);
    t_byte;
    t_chain;
    t_prio;
    t_zero;
    finish_run;
  end

  initial begin
    repeat (WD_MAX) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule